// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Carry-Out

This block forms the second operand of a data-processing operation from a 32-bit source word. It also forms the carry that the shift produces. One of four shift kinds is applied: logical left, logical right, arithmetic right or rotate right. The shift amount comes from one of two places:

- a 5-bit amount that is part of the instruction word;
- the low byte of a register.

The block is purely combinational. The operand and carry follow the inputs in the same cycle, and the block has no clock, no reset and no state.

A zero, a full-width or an oversized amount does not simply shift. Each follows its own rule, and those rules differ between the two amount sources. Internally the amount is first sorted into one of five classes:

- keep: the operand passes unchanged;
- partial: a shift by 1 to 31;
- whole: a shift by exactly the word width;
- beyond: a shift past the word width;
- extended rotate: a one-bit rotate through the incoming carry.

A single selector then picks the operand and carry for the class and the shift kind. The data path has no sequencing; the class stands where a state would stand in a sequential block.

Top module: `opnd_shifter`

## Requirements
- R1: With the register source selected (`use_reg_i` = 1) and a register amount of 0, every shift kind returns `rm_i` unchanged and `carry_o` equals `carry_i`. Shift kind codes on `shtype_i` are 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right.
- R2: Register logical left by n:
  - for n in 1..31, the operand is `rm_i` shifted left by n and the carry is `rm_i[32-n]`;
  - for n = 32, the operand is 0 and the carry is `rm_i[0]`;
  - for n > 32, both the operand and the carry are 0.
- R3: Register logical right by n:
  - for n in 1..31, the operand is `rm_i` shifted right by n with zero fill and the carry is `rm_i[n-1]`;
  - for n = 32, the operand is 0 and the carry is `rm_i[31]`;
  - for n > 32, both the operand and the carry are 0.
- R4: Register arithmetic right by n:
  - for n in 1..31, the operand is shifted with copies of `rm_i[31]` filling from the top and the carry is `rm_i[n-1]`;
  - for n >= 32, every operand bit equals `rm_i[31]` and the carry is `rm_i[31]`.
- R5: Register rotate right by a nonzero amount:
  - if the low 5 bits are 0, the operand is `rm_i` and the carry is `rm_i[31]`;
  - otherwise the operand is `rm_i` rotated right by the low 5 bits (k) and the carry is `rm_i[k-1]`.
- R6: With the instruction source selected (`use_reg_i` = 0), a logical left by an `imm_amt_i` of 0 returns `rm_i` and keeps `carry_i`.
- R7: With the instruction source, a logical right or arithmetic right by an `imm_amt_i` of 0 behaves exactly as a shift by 32, following the n = 32 rules of R3 and R4.
- R8: With the instruction source, a rotate right by an `imm_amt_i` of 0 is the extended rotate: the operand is {`carry_i`, `rm_i[31:1]`} and the carry is `rm_i[0]`.
- R9: With the instruction source and an `imm_amt_i` n in 1..31, the result and carry are those of the register source with amount n, for all four shift kinds.
- R10: The outputs depend only on the present inputs. A change of any input shows on `opnd_o` and `carry_o` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rm_i | input | 32 | Source word to be shifted |
| shtype_i | input | 2 | Shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| use_reg_i | input | 1 | 1 selects the register amount, 0 selects the instruction amount |
| imm_amt_i | input | 5 | Shift amount held in the instruction word |
| reg_amt_i | input | 8 | Shift amount taken from the low byte of a register |
| carry_i | input | 1 | Incoming carry flag |
| opnd_o | output | 32 | Shifted second operand |
| carry_o | output | 1 | Carry produced by the shifter |

## Verification
The assertions check the boundary classes whenever the inputs change:

- a zero register amount passes the word and the carry through (R1);
- left and right logical shifts past 32 clear everything (R2, R3);
- arithmetic right by 32 or more fills with the sign bit (R4);
- a register rotate by a multiple of 32 returns the word unchanged (R5);
- the three zero instruction-amount encodings (R6, R7, R8).

The partial shifts by 1 to 31 need exact bit positions and exact carry indices, which the bench's scenarios check against an independent bit-by-bit model and against hand-worked literal values. Whether the instruction amount truly matches the register amount for the same n (R9) is also checked only by those scenarios. So is the immediate response to input changes within one cycle (R10).

// File: rtl/opshift_pkg.sv
package opshift_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } sh_type_e;

    typedef enum logic [2:0] {
        AC_KEEP   = 3'd0,
        AC_PART   = 3'd1,
        AC_WHOLE  = 3'd2,
        AC_BEYOND = 3'd3,
        AC_RRX    = 3'd4
    } amt_class_e;

endpackage

// File: rtl/opshift_amt_decode.sv
module opshift_amt_decode
    import opshift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8,
    parameter int AMT_W     = $clog2(DATA_W)
) (
    input  sh_type_e             shtype,
    input  logic                 use_reg,
    input  logic [AMT_W-1:0]     imm_amt,
    input  logic [REG_AMT_W-1:0] reg_amt,
    output amt_class_e           cls,
    output logic [AMT_W-1:0]     amt
);

    localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

    always_comb begin
        cls = AC_KEEP;
        amt = '0;
        if (use_reg) begin
            if (reg_amt == '0) begin
                cls = AC_KEEP;
            end else if (shtype == SH_ROR) begin
                amt = reg_amt[AMT_W-1:0];
                cls = (reg_amt[AMT_W-1:0] == '0) ? AC_WHOLE : AC_PART;
            end else if (reg_amt < FULL_AMT) begin
                amt = reg_amt[AMT_W-1:0];
                cls = AC_PART;
            end else if (reg_amt == FULL_AMT) begin
                cls = AC_WHOLE;
            end else begin
                cls = AC_BEYOND;
            end
        end else begin
            if (imm_amt == '0) begin
                unique case (shtype)
                    SH_LSL:         cls = AC_KEEP;
                    SH_LSR, SH_ASR: cls = AC_WHOLE;
                    SH_ROR:         cls = AC_RRX;
                    default:        cls = AC_KEEP;
                endcase
            end else begin
                amt = imm_amt;
                cls = AC_PART;
            end
        end
    end

endmodule

// File: rtl/opshift_barrel.sv
module opshift_barrel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] rm,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] lsl_res,
    output logic              lsl_c,
    output logic [DATA_W-1:0] lsr_res,
    output logic              lsr_c,
    output logic [DATA_W-1:0] asr_res,
    output logic              asr_c,
    output logic [DATA_W-1:0] ror_res,
    output logic              ror_c
);

    logic [DATA_W:0]     lsl_ext;
    logic [DATA_W:0]     lsr_ext;
    logic [DATA_W:0]     asr_ext;
    logic [2*DATA_W-1:0] ror_dbl;

    // A guard bit beside the word catches the last bit shifted out.
    always_comb begin
        lsl_ext = {1'b0, rm} << amt;
        lsr_ext = {rm, 1'b0} >> amt;
        asr_ext = $signed({rm, 1'b0}) >>> amt;
        ror_dbl = {rm, rm} >> amt;
    end

    always_comb begin
        lsl_res = lsl_ext[DATA_W-1:0];
        lsl_c   = lsl_ext[DATA_W];
        lsr_res = lsr_ext[DATA_W:1];
        lsr_c   = lsr_ext[0];
        asr_res = asr_ext[DATA_W:1];
        asr_c   = asr_ext[0];
        ror_res = ror_dbl[DATA_W-1:0];
        ror_c   = ror_dbl[DATA_W-1];
    end

endmodule

// File: rtl/opshift_select.sv
module opshift_select
    import opshift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  sh_type_e          shtype,
    input  amt_class_e        cls,
    input  logic [DATA_W-1:0] rm,
    input  logic              cin,
    input  logic [DATA_W-1:0] lsl_res,
    input  logic              lsl_c,
    input  logic [DATA_W-1:0] lsr_res,
    input  logic              lsr_c,
    input  logic [DATA_W-1:0] asr_res,
    input  logic              asr_c,
    input  logic [DATA_W-1:0] ror_res,
    input  logic              ror_c,
    output logic [DATA_W-1:0] opnd,
    output logic              cout
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] sign_fill;

    always_comb sign_fill = {DATA_W{rm[MSB]}};

    always_comb begin
        opnd = rm;
        cout = cin;
        unique case (cls)
            AC_KEEP: begin
                opnd = rm;
                cout = cin;
            end
            AC_PART: begin
                unique case (shtype)
                    SH_LSL: begin opnd = lsl_res; cout = lsl_c; end
                    SH_LSR: begin opnd = lsr_res; cout = lsr_c; end
                    SH_ASR: begin opnd = asr_res; cout = asr_c; end
                    SH_ROR: begin opnd = ror_res; cout = ror_c; end
                    default: begin opnd = rm; cout = cin; end
                endcase
            end
            AC_WHOLE: begin
                unique case (shtype)
                    SH_LSL: begin opnd = '0;        cout = rm[0];   end
                    SH_LSR: begin opnd = '0;        cout = rm[MSB]; end
                    SH_ASR: begin opnd = sign_fill; cout = rm[MSB]; end
                    SH_ROR: begin opnd = rm;        cout = rm[MSB]; end
                    default: begin opnd = rm; cout = cin; end
                endcase
            end
            AC_BEYOND: begin
                unique case (shtype)
                    SH_LSL, SH_LSR: begin opnd = '0; cout = 1'b0; end
                    SH_ASR: begin opnd = sign_fill; cout = rm[MSB]; end
                    SH_ROR: begin opnd = rm;        cout = rm[MSB]; end
                    default: begin opnd = rm; cout = cin; end
                endcase
            end
            AC_RRX: begin
                opnd = {cin, rm[MSB:1]};
                cout = rm[0];
            end
            default: begin
                opnd = rm;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
    import opshift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_AMT_W = 8
) (
    input  logic [DATA_W-1:0]         rm_i,
    input  logic [1:0]                shtype_i,
    input  logic                      use_reg_i,
    input  logic [$clog2(DATA_W)-1:0] imm_amt_i,
    input  logic [REG_AMT_W-1:0]      reg_amt_i,
    input  logic                      carry_i,
    output logic [DATA_W-1:0]         opnd_o,
    output logic                      carry_o
);

    localparam int AMT_W = $clog2(DATA_W);
    localparam int MSB   = DATA_W - 1;
    localparam logic [REG_AMT_W-1:0] FULL_AMT = REG_AMT_W'(DATA_W);

    sh_type_e          shtype;
    amt_class_e        cls;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] lsl_res, lsr_res, asr_res, ror_res;
    logic              lsl_c, lsr_c, asr_c, ror_c;

    always_comb shtype = sh_type_e'(shtype_i);

    opshift_amt_decode #(
        .DATA_W   (DATA_W),
        .REG_AMT_W(REG_AMT_W),
        .AMT_W    (AMT_W)
    ) u_decode (
        .shtype  (shtype),
        .use_reg (use_reg_i),
        .imm_amt (imm_amt_i),
        .reg_amt (reg_amt_i),
        .cls     (cls),
        .amt     (amt)
    );

    opshift_barrel #(
        .DATA_W(DATA_W),
        .AMT_W (AMT_W)
    ) u_barrel (
        .rm      (rm_i),
        .amt     (amt),
        .lsl_res (lsl_res),
        .lsl_c   (lsl_c),
        .lsr_res (lsr_res),
        .lsr_c   (lsr_c),
        .asr_res (asr_res),
        .asr_c   (asr_c),
        .ror_res (ror_res),
        .ror_c   (ror_c)
    );

    opshift_select #(
        .DATA_W(DATA_W)
    ) u_select (
        .shtype  (shtype),
        .cls     (cls),
        .rm      (rm_i),
        .cin     (carry_i),
        .lsl_res (lsl_res),
        .lsl_c   (lsl_c),
        .lsr_res (lsr_res),
        .lsr_c   (lsr_c),
        .asr_res (asr_res),
        .asr_c   (asr_c),
        .ror_res (ror_res),
        .ror_c   (ror_c),
        .opnd    (opnd_o),
        .cout    (carry_o)
    );

    // Port-level checks of the boundary encodings.
    always_comb begin
        if (use_reg_i && reg_amt_i == '0)
            AST_REG_ZERO_PASS: assert (opnd_o == rm_i && carry_o == carry_i); // R1
        if (use_reg_i && shtype_i == 2'b00 && reg_amt_i > FULL_AMT)
            AST_LSL_BEYOND_CLEAR: assert (opnd_o == '0 && carry_o == 1'b0); // R2
        if (use_reg_i && shtype_i == 2'b01 && reg_amt_i > FULL_AMT)
            AST_LSR_BEYOND_CLEAR: assert (opnd_o == '0 && carry_o == 1'b0); // R3
        if (use_reg_i && shtype_i == 2'b10 && reg_amt_i >= FULL_AMT)
            AST_ASR_SIGN_FILL: assert (opnd_o == {DATA_W{rm_i[MSB]}} && carry_o == rm_i[MSB]); // R4
        if (use_reg_i && shtype_i == 2'b11 && reg_amt_i != '0 && reg_amt_i[AMT_W-1:0] == '0)
            AST_ROR_FULL_TURN: assert (opnd_o == rm_i && carry_o == rm_i[MSB]); // R5
        if (!use_reg_i && shtype_i == 2'b00 && imm_amt_i == '0)
            AST_IMM_LSL_ZERO: assert (opnd_o == rm_i && carry_o == carry_i); // R6
        if (!use_reg_i && shtype_i == 2'b01 && imm_amt_i == '0)
            AST_IMM_LSR_ZERO: assert (opnd_o == '0 && carry_o == rm_i[MSB]); // R7
        if (!use_reg_i && shtype_i == 2'b11 && imm_amt_i == '0)
            AST_IMM_RRX: assert (opnd_o == {carry_i, rm_i[MSB:1]} && carry_o == rm_i[0]); // R8
    end

endmodule

// File: tb/opnd_shifter_tb.sv
module opnd_shifter_tb_top;

    logic        clk = 1'b0;
    logic [31:0] rm;
    logic [1:0]  shtype;
    logic        use_reg;
    logic [4:0]  imm_amt;
    logic [7:0]  reg_amt;
    logic        cin;
    logic [31:0] opnd;
    logic        cout;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    opnd_shifter dut_i (
        .rm_i      (rm),
        .shtype_i  (shtype),
        .use_reg_i (use_reg),
        .imm_amt_i (imm_amt),
        .reg_amt_i (reg_amt),
        .carry_i   (cin),
        .opnd_o    (opnd),
        .carry_o   (cout)
    );

    // Independent bit-by-bit model built from the requirements.
    function automatic logic [32:0] model(input logic [1:0] ty, input logic ureg,
                                          input logic [4:0] imm, input logic [7:0] ra,
                                          input logic [31:0] w, input logic c_in);
        logic [31:0] r;
        logic        c;
        int          n;
        r = w;
        c = c_in;
        if (!ureg) begin
            if (imm == 0 && ty == 2'd3) return {w[0], c_in, w[31:1]};
            if (imm == 0 && ty != 2'd0) n = 32;
            else n = imm;
        end else begin
            n = ra;
        end
        if (n == 0) return {c, r};
        case (ty)
            2'd0: begin
                if (n < 32) begin
                    for (int i = 0; i < 32; i++) r[i] = (i >= n) ? w[i-n] : 1'b0;
                    c = w[32-n];
                end else if (n == 32) begin r = 0; c = w[0]; end
                else begin r = 0; c = 1'b0; end
            end
            2'd1: begin
                if (n < 32) begin
                    for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? w[i+n] : 1'b0;
                    c = w[n-1];
                end else if (n == 32) begin r = 0; c = w[31]; end
                else begin r = 0; c = 1'b0; end
            end
            2'd2: begin
                if (n < 32) begin
                    for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? w[i+n] : w[31];
                    c = w[n-1];
                end else begin r = {32{w[31]}}; c = w[31]; end
            end
            default: begin
                n = n % 32;
                if (n == 0) begin r = w; c = w[31]; end
                else begin
                    for (int i = 0; i < 32; i++) r[i] = w[(i+n)%32];
                    c = w[n-1];
                end
            end
        endcase
        return {c, r};
    endfunction

    task automatic drive(input logic [1:0] ty, input logic ureg, input logic [4:0] imm,
                         input logic [7:0] ra, input logic [31:0] w, input logic c_in);
        @(posedge clk);
        shtype = ty; use_reg = ureg; imm_amt = imm; reg_amt = ra; rm = w; cin = c_in;
        @(negedge clk);
    endtask

    task automatic compare(input string tag, input logic [31:0] exp_o, input logic exp_c);
        checks++;
        if (opnd !== exp_o || cout !== exp_c) begin
            fails++;
            $display("FAIL %s: got opnd=%h carry=%b expected opnd=%h carry=%b",
                     tag, opnd, cout, exp_o, exp_c);
        end
    endtask

    task automatic run(input string tag, input logic [1:0] ty, input logic ureg,
                       input logic [4:0] imm, input logic [7:0] ra,
                       input logic [31:0] w, input logic c_in);
        logic [32:0] e;
        drive(ty, ureg, imm, ra, w, c_in);
        e = model(ty, ureg, imm, ra, w, c_in);
        compare(tag, e[31:0], e[32]);
    endtask

    task automatic t_idle_state();
        drive(2'd0, 1'b0, 5'd0, 8'd0, 32'h0, 1'b0);
        compare("R6 idle zero inputs", 32'h0, 1'b0);
    endtask

    task automatic t_reg_zero();
        for (int t = 0; t < 4; t++) begin
            run("R1 reg amount zero c0", 2'(t), 1'b1, 5'd7, 8'd0, 32'hC000_0001, 1'b0);
            run("R1 reg amount zero c1", 2'(t), 1'b1, 5'd7, 8'd0, 32'h1234_5678, 1'b1);
        end
    endtask

    task automatic t_reg_lsl();
        drive(2'd0, 1'b1, 5'd0, 8'd1, 32'hC000_0001, 1'b0);
        compare("R2 lsl1 literal", 32'h8000_0002, 1'b1);
        drive(2'd0, 1'b1, 5'd0, 8'd1, 32'h4000_0001, 1'b1);
        compare("R2 lsl1 carry0 literal", 32'h8000_0002, 1'b0);
        drive(2'd0, 1'b1, 5'd0, 8'd32, 32'hC000_0001, 1'b0);
        compare("R2 lsl32 literal", 32'h0, 1'b1);
        drive(2'd0, 1'b1, 5'd0, 8'd33, 32'hFFFF_FFFF, 1'b1);
        compare("R2 lsl33 literal", 32'h0, 1'b0);
        for (int n = 1; n < 40; n++)
            run("R2 lsl sweep", 2'd0, 1'b1, 5'd0, 8'(n), 32'hA5C3_0F69, 1'b0);
        run("R2 lsl255", 2'd0, 1'b1, 5'd0, 8'd255, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_reg_lsr();
        drive(2'd1, 1'b1, 5'd0, 8'd1, 32'hC000_0001, 1'b0);
        compare("R3 lsr1 literal", 32'h6000_0000, 1'b1);
        drive(2'd1, 1'b1, 5'd0, 8'd32, 32'hC000_0001, 1'b0);
        compare("R3 lsr32 literal", 32'h0, 1'b1);
        drive(2'd1, 1'b1, 5'd0, 8'd32, 32'h4000_0001, 1'b1);
        compare("R3 lsr32 carry0 literal", 32'h0, 1'b0);
        for (int n = 1; n < 40; n++)
            run("R3 lsr sweep", 2'd1, 1'b1, 5'd0, 8'(n), 32'h9ABC_DEF1, 1'b1);
    endtask

    task automatic t_reg_asr();
        drive(2'd2, 1'b1, 5'd0, 8'd1, 32'hC000_0001, 1'b0);
        compare("R4 asr1 literal", 32'hE000_0000, 1'b1);
        drive(2'd2, 1'b1, 5'd0, 8'd32, 32'hC000_0001, 1'b0);
        compare("R4 asr32 negative literal", 32'hFFFF_FFFF, 1'b1);
        drive(2'd2, 1'b1, 5'd0, 8'd200, 32'h4000_0001, 1'b1);
        compare("R4 asr200 positive literal", 32'h0, 1'b0);
        for (int n = 1; n < 40; n++) begin
            run("R4 asr sweep neg", 2'd2, 1'b1, 5'd0, 8'(n), 32'h8765_4321, 1'b0);
            run("R4 asr sweep pos", 2'd2, 1'b1, 5'd0, 8'(n), 32'h7654_3218, 1'b1);
        end
    endtask

    task automatic t_reg_ror();
        drive(2'd3, 1'b1, 5'd0, 8'd1, 32'hC000_0001, 1'b0);
        compare("R5 ror1 literal", 32'hE000_0000, 1'b1);
        drive(2'd3, 1'b1, 5'd0, 8'd32, 32'h4000_0001, 1'b1);
        compare("R5 ror32 literal", 32'h4000_0001, 1'b0);
        drive(2'd3, 1'b1, 5'd0, 8'd33, 32'h4000_0001, 1'b0);
        compare("R5 ror33 literal", 32'hA000_0000, 1'b1);
        for (int n = 1; n < 256; n += 7)
            run("R5 ror sweep", 2'd3, 1'b1, 5'd0, 8'(n), 32'hF0E1_D2C3, 1'b0);
        run("R5 ror64", 2'd3, 1'b1, 5'd0, 8'd64, 32'h8000_0000, 1'b0);
        run("R5 ror224", 2'd3, 1'b1, 5'd0, 8'd224, 32'h1234_5678, 1'b1);
    endtask

    task automatic t_imm_zero();
        drive(2'd0, 1'b0, 5'd0, 8'd99, 32'hC000_0001, 1'b1);
        compare("R6 imm lsl0 literal", 32'hC000_0001, 1'b1);
        drive(2'd1, 1'b0, 5'd0, 8'd0, 32'hC000_0001, 1'b0);
        compare("R7 imm lsr0 literal", 32'h0, 1'b1);
        drive(2'd2, 1'b0, 5'd0, 8'd0, 32'hC000_0001, 1'b0);
        compare("R7 imm asr0 neg literal", 32'hFFFF_FFFF, 1'b1);
        drive(2'd2, 1'b0, 5'd0, 8'd0, 32'h4000_0001, 1'b1);
        compare("R7 imm asr0 pos literal", 32'h0, 1'b0);
        drive(2'd3, 1'b0, 5'd0, 8'd0, 32'hC000_0001, 1'b0);
        compare("R8 imm rrx c0 literal", 32'h6000_0000, 1'b1);
        drive(2'd3, 1'b0, 5'd0, 8'd0, 32'hC000_0000, 1'b1);
        compare("R8 imm rrx c1 literal", 32'hE000_0000, 1'b0);
    endtask

    task automatic t_imm_nonzero();
        drive(2'd0, 1'b0, 5'd31, 8'd0, 32'hC000_0001, 1'b0);
        compare("R9 imm lsl31 literal", 32'h8000_0000, 1'b0);
        drive(2'd2, 1'b0, 5'd31, 8'd0, 32'hC000_0001, 1'b0);
        compare("R9 imm asr31 literal", 32'hFFFF_FFFF, 1'b1);
        for (int t = 0; t < 4; t++)
            for (int n = 1; n < 32; n++)
                run("R9 imm sweep", 2'(t), 1'b0, 5'(n), 8'd0, 32'h5A96_C33C ^ 32'(n), 1'(n));
    endtask

    task automatic t_comb_response();
        @(posedge clk);
        shtype = 2'd1; use_reg = 1'b1; reg_amt = 8'd4; rm = 32'h0000_00F8; cin = 1'b0;
        #1;
        compare("R10 same-cycle response", 32'h0000_000F, 1'b1);
        rm = 32'h0000_0070;
        #1;
        compare("R10 change without edge", 32'h0000_0007, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rm = '0; shtype = '0; use_reg = 1'b0; imm_amt = '0; reg_amt = '0; cin = 1'b0;
        t_idle_state();
        t_reg_zero();
        t_reg_lsl();
        t_reg_lsr();
        t_reg_asr();
        t_reg_ror();
        t_imm_zero();
        t_imm_nonzero();
        t_comb_response();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule